// File: doc/BRIEF.md
# Packet-Granular Flow Control Stage

This block is one hop of a packet router. It sits between a single upstream flit input and a single downstream flit output and holds packets in a local flit buffer. Buffer space and the downstream link are handed out per whole packet, never per flit. A static parameter selects one of two start rules for forwarding. In store-and-forward mode a packet waits until its tail has arrived. In cut-through mode a packet may leave as soon as the downstream router can hold all of it.

Each flit comes with a head marker and a tail marker. A one-flit packet carries both. The head flit's low data bits give the packet length, and the upper bits carry the route, which passes through unchanged. The stage keeps a credit count of free downstream slots. The downstream side returns one credit for each slot it frees.

Top module: `pkt_fc_stage`

## Requirements
- R1: After reset `out_valid` is 0. `in_ready` is 1 for any head whose length is at most the buffer depth, and the credit count equals `CREDITS`.
- R2: On a head flit, `in_data[2:0]` holds the packet length minus one, so lengths run from 1 to 8. A one-flit packet has `in_head` and `in_tail` both set, and it leaves with `out_head` and `out_tail` both set.
- R3: A new head is admitted only when the free buffer slots are at least its length. Free slots are the depth minus the slots still reserved for packets held in the buffer. Otherwise `in_ready` is 0 while that head is presented. Body and tail flits of an admitted packet are always ready.
- R4: In store-and-forward mode, a head flit never leaves before its tail has been accepted. When credits are available, the head appears on the output in the cycle after the tail's acceptance edge, and the remaining flits follow one per cycle.
- R5: In cut-through mode, a head leaves only when the credit count is at least the packet length. When that holds, each flit appears on the output in the cycle after its own acceptance edge.
- R6: Flits leave in arrival order with their data and head/tail markers unchanged.
- R7: Once a packet has been granted the link, no flit of another packet appears on the output until its tail has left.
- R8: Credits are consumed in one of two ways. In store-and-forward mode, a flit is sent only with a nonzero credit count, and each flit takes one credit. In cut-through mode, the whole packet length is taken from the count at grant. In both modes each `credit_ret` pulse adds one credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream flit valid |
| in_ready | output | 1 | Stage can take the presented flit |
| in_head | input | 1 | Presented flit is a packet head |
| in_tail | input | 1 | Presented flit is a packet tail |
| in_data | input | DW | Flit payload; on a head, bits [2:0] = length-1 |
| out_valid | output | 1 | Downstream flit valid (registered) |
| out_head | output | 1 | Outgoing flit is a head |
| out_tail | output | 1 | Outgoing flit is a tail |
| out_data | output | DW | Outgoing flit payload |
| credit_ret | input | 1 | One downstream slot freed |

## Verification
The assertions rely on a well-formed upstream. `in_head` marks exactly the first flit of each packet and `in_tail` exactly the last. The number of flits in a packet equals the length written in its head. `credit_ret` never returns more slots than the stage has sent. The bench meets these conditions by building every packet from one length value, so the head field and the tail position always agree. It also returns credits only as echoes of observed output flits, or as deliberate pulses that stay within the flits already sent.

// File: rtl/pkt_fc_stage.sv
module pkt_fc_stage #(
  parameter int DW      = 16,
  parameter int DEPTH   = 8,
  parameter int MAXLEN  = 8,
  parameter int CREDITS = 8,
  parameter bit CUT     = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_head,
  input  logic          in_tail,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_head,
  output logic          out_tail,
  output logic [DW-1:0] out_data,
  input  logic          credit_ret
);
  localparam int LW = $clog2(MAXLEN);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BIG = (DEPTH > CREDITS) ? DEPTH : CREDITS;
  localparam int CW = $clog2(BIG + MAXLEN + 1);
  localparam int EW = DW + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr, rd;
  logic [CW-1:0] cnt, alloc, cred, done_pk;
  logic          in_mid, active;

  logic [EW-1:0] top;
  logic [CW-1:0] in_len, top_len;
  logic          acc, new_pkt, top_tail, start_ok, pop;

  assign top      = mem[rd];
  assign top_tail = top[DW];
  assign in_len   = CW'(in_data[LW-1:0]) + CW'(1);
  assign top_len  = CW'(top[LW-1:0]) + CW'(1);

  assign in_ready = in_mid || ((CW'(DEPTH) - alloc) >= in_len);
  assign acc      = in_valid && in_ready;
  assign new_pkt  = acc && !in_mid;

  generate
    if (CUT) begin : g_vct
      assign start_ok = cred >= top_len;
    end else begin : g_saf
      assign start_ok = (done_pk != '0) && (cred != '0);
    end
  endgenerate

  assign pop = (cnt != '0) && (active ? (CUT || cred != '0) : start_ok);

  logic [CW-1:0] cred_take;
  assign cred_take = CUT ? ((pop && !active) ? top_len : '0) : CW'(pop);

  always_ff @(posedge clk) begin
    if (acc) mem[wr] <= {in_head, in_tail, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr <= '0;
      rd <= '0;
      cnt <= '0;
      alloc <= '0;
      done_pk <= '0;
      cred <= CW'(CREDITS);
      in_mid <= 1'b0;
      active <= 1'b0;
      out_valid <= 1'b0;
      out_head <= 1'b0;
      out_tail <= 1'b0;
      out_data <= '0;
    end else begin
      if (acc) wr <= (wr == AW'(DEPTH - 1)) ? '0 : wr + AW'(1);
      if (pop) rd <= (rd == AW'(DEPTH - 1)) ? '0 : rd + AW'(1);
      cnt     <= cnt + CW'(acc) - CW'(pop);
      alloc   <= alloc + (new_pkt ? in_len : '0) - CW'(pop);
      done_pk <= done_pk + CW'(acc && in_tail) - CW'(pop && top_tail);
      cred    <= cred + CW'(credit_ret) - cred_take;
      if (acc) in_mid <= !in_tail;
      if (pop) active <= !top_tail;
      out_valid <= pop;
      if (pop) {out_head, out_tail, out_data} <= top;
    end
  end
endmodule

// File: rtl/pkt_fc_stage_chk.sv
module pkt_fc_stage_chk #(
  parameter int DW = 16,
  parameter int DEPTH = 8,
  parameter int MAXLEN = 8,
  parameter int CREDITS = 8,
  parameter bit CUT = 1'b0,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_tail,
  input logic          out_valid,
  input logic          out_head,
  input logic          out_tail,
  input logic [DW-1:0] out_data,
  input logic [CW-1:0] cred,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] alloc
);
  localparam int LW = $clog2(MAXLEN);
  logic [7:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else pend <= pend + 8'(in_valid && in_ready && in_tail) - 8'(out_valid && out_tail);
  end

  // R3
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= alloc) && (alloc <= CW'(DEPTH)));

  // R4
  saf_tail_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!CUT && out_valid && out_head) |-> (pend != '0));

  // R5
  vct_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CUT && out_valid && out_head) |-> ($past(cred) >= CW'(out_data[LW-1:0]) + CW'(1)));

  // R7
  pkt_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_tail) |=> !(out_valid && out_head));

  // R8
  saf_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!CUT && out_valid) |-> ($past(cred) != '0));

  // R8
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cred <= CW'(CREDITS));
endmodule

bind pkt_fc_stage pkt_fc_stage_chk #(
  .DW(DW), .DEPTH(DEPTH), .MAXLEN(MAXLEN), .CREDITS(CREDITS), .CUT(CUT), .CW(CW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_tail(in_tail), .out_valid(out_valid), .out_head(out_head),
  .out_tail(out_tail), .out_data(out_data), .cred(cred), .cnt(cnt), .alloc(alloc)
);

// File: tb/test_pkt_fc_stage.sv
`timescale 1ns/1ps
module test_pkt_fc_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic v = 1'b0, hd = 1'b0, tl = 1'b0;
  logic [15:0] dat = '0;
  logic rdy_a, rdy_b, ov_a, ov_b, oh_a, oh_b, ot_a, ot_b;
  logic [15:0] od_a, od_b;
  logic cr_a = 1'b0, cr_b = 1'b0, ret_en = 1'b1, man_cr = 1'b0;

  pkt_fc_stage #(.CUT(1'b0)) i_pkt_fc_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(v && rdy_b), .in_ready(rdy_a),
    .in_head(hd), .in_tail(tl), .in_data(dat), .out_valid(ov_a),
    .out_head(oh_a), .out_tail(ot_a), .out_data(od_a), .credit_ret(cr_a));

  pkt_fc_stage #(.CUT(1'b1)) i_pkt_fc_stage_ct (
    .clk(clk), .rst_n(rst_n), .in_valid(v && rdy_a), .in_ready(rdy_b),
    .in_head(hd), .in_tail(tl), .in_data(dat), .out_valid(ov_b),
    .out_head(oh_b), .out_tail(ot_b), .out_data(od_b), .credit_ret(cr_b));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nin = 0, na = 0, nb = 0, nchk = 0, nerr = 0;
  int flit_acc [256];
  logic [17:0] exp_fl [256];
  int ta [256], tb [256];
  logic [17:0] fa [256], fb [256];

  always @(negedge clk) begin
    if (ov_a) begin fa[na] = {oh_a, ot_a, od_a}; ta[na] = cyc; na++; end
    if (ov_b) begin fb[nb] = {oh_b, ot_b, od_b}; tb[nb] = cyc; nb++; end
    cr_a = (ret_en && ov_a) || man_cr;
    cr_b = (ret_en && ov_b) || man_cr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic send_flit(input logic h, input logic t, input logic [15:0] d);
    v = 1'b1; hd = h; tl = t; dat = d;
    #1;
    while (!(rdy_a && rdy_b)) begin @(negedge clk); #1; end
    flit_acc[nin] = cyc + 1;
    exp_fl[nin] = {h, t, d};
    nin++;
    @(negedge clk);
  endtask

  task automatic send_pkt(input int len, input int gap, input int route);
    for (int j = 0; j < len; j++) begin
      if (j == 0) send_flit(1'b1, len == 1, {13'(route), 3'(len - 1)});
      else send_flit(1'b0, j == len - 1, 16'h4000 + 16'(nin));
      if (gap > 0 && j < len - 1) begin v = 1'b0; repeat (gap) @(negedge clk); end
    end
    v = 1'b0; hd = 1'b0; tl = 1'b0;
  endtask

  task automatic credits(input int n);
    repeat (n) begin man_cr = 1'b1; @(negedge clk); end
    man_cr = 1'b0;
  endtask

  // len, inter-flit gap
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{1, 0}, '{3, 0}, '{8, 0}, '{4, 2}, '{2, 1}, '{6, 0}};

  initial begin
    #(8 * 100000);
    nerr++; nchk++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int first, len, ba, bb, ok;
    repeat (3) @(negedge clk);
    dat = 16'h0007;
    #1;
    chk(!ov_a && !ov_b, "R1 out_valid after reset", int'(ov_a) + int'(ov_b), 0);
    chk(rdy_a && rdy_b, "R1 ready for length-8 head", int'(rdy_a) + int'(rdy_b), 2);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      first = nin; len = VEC[i][0];
      send_pkt(len, VEC[i][1], 100 + i);
      repeat (20) @(negedge clk);
      chk(na == nin && nb == nin, "R6 flit count", na + nb, 2 * nin);
      chk(ta[first] == flit_acc[first + len - 1] + 1, "R4 saf head start",
          ta[first], flit_acc[first + len - 1] + 1);
      chk(tb[first] == flit_acc[first] + 1, "R5 vct head start", tb[first], flit_acc[first] + 1);
      ok = 1;
      for (int k = first; k < first + len; k++) begin
        if (fa[k] != exp_fl[k] || fb[k] != exp_fl[k]) ok = 0;
      end
      chk(ok == 1, "R6 R2 order data flags", ok, 1);
      ok = 1;
      for (int k = first; k < first + len; k++) begin
        if (ta[k] != ta[first] + (k - first)) ok = 0;
        if (tb[k] != flit_acc[k] + 1) ok = 0;
      end
      chk(ok == 1, "R7 R5 flit timing", ok, 1);
    end
    chk(fa[0][17] && fa[0][16], "R2 single flit head and tail", int'(fa[0][17:16]), 3);

    ret_en = 1'b0;
    send_pkt(8, 0, 7);
    repeat (20) @(negedge clk);
    ba = na; bb = nb;
    send_pkt(3, 0, 8);
    repeat (10) @(negedge clk);
    chk(na == ba, "R8 saf holds at zero credit", na - ba, 0);
    chk(nb == bb, "R5 vct holds at zero credit", nb - bb, 0);
    credits(2);
    repeat (5) @(negedge clk);
    chk(na == ba + 2, "R8 saf one flit per credit", na - ba, 2);
    chk(nb == bb, "R5 vct waits for full length", nb - bb, 0);
    credits(1);
    repeat (6) @(negedge clk);
    chk(na == ba + 3, "R8 saf finishes packet", na - ba, 3);
    chk(nb == bb + 3, "R5 vct sends whole packet", nb - bb, 3);
    chk(tb[bb + 2] == tb[bb] + 2, "R7 vct flits back to back", tb[bb + 2] - tb[bb], 2);

    send_pkt(5, 0, 9);
    dat = 16'h0003; hd = 1'b1;
    #1;
    chk(!rdy_a && !rdy_b, "R3 head of 4 refused with 3 free", int'(rdy_a) + int'(rdy_b), 0);
    dat = 16'h0002;
    #1;
    chk(rdy_a && rdy_b, "R3 head of 3 admitted with 3 free", int'(rdy_a) + int'(rdy_b), 2);
    @(negedge clk);
    send_pkt(3, 0, 10);
    dat = 16'h0000; hd = 1'b1;
    #1;
    chk(!rdy_a && !rdy_b, "R3 full buffer refuses head", int'(rdy_a) + int'(rdy_b), 0);
    hd = 1'b0;
    @(negedge clk);
    credits(8);
    repeat (30) @(negedge clk);
    chk(na == nin && nb == nin, "R8 drain after credits", na + nb, 2 * nin);
    dat = 16'h0007;
    #1;
    chk(rdy_a && rdy_b, "R3 space released after drain", int'(rdy_a) + int'(rdy_b), 2);
    ok = 1;
    for (int k = 0; k < nin; k++) if (fa[k] != exp_fl[k] || fb[k] != exp_fl[k]) ok = 0;
    chk(ok == 1, "R6 full stream order", ok, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule